// File: doc/BRIEF.md
# PFC Valley-Switching Gate Timer

This block drives the power switch of a boost power-factor stage that runs at the boundary between continuous and discontinuous conduction. Every switching cycle goes through four steps. The switch turns on. The gate stays high for a programmed number of clock counts. The controller then waits for the inductor current to reach zero (demagnetization). Finally it waits for a minimum of the drain ringing (a valley) before it starts the next stroke. All flag inputs arrive already synchronized to the block clock.

Real signals can go missing, so two internal timers provide fallback events. A zero-current event is produced when demagnetization stays silent too long after the gate falls. Valley events are produced at a fixed interval when no valley is reported. A period counter holds every rising edge of the gate at least a minimum number of clocks after the one before. At light load this forces the stage into discontinuous conduction, and turn-on still happens only on a valley.

Several inputs stop switching: overvoltage, brownout and the light-load request. Switching resumes once they clear. The block does not switch at all until the output-sense input has shown once that the loop is closed.

Top module: `pfc_valley_ctrl`

## Requirements
- R1: After reset the gate is low. No stroke starts until `vout_ok_i` has been seen high in at least one cycle, and this arming persists until the next reset.
- R2: A stroke holds the gate high for `on_time_i` clock cycles, sampled in the cycle of turn-on. A value of 0 gives one cycle. Changes to `on_time_i` during a stroke have no effect on that stroke.
- R3: `ocp_i` high while the gate is high forces the gate low in the same cycle and ends the on-time. The gate stays low after `ocp_i` drops.
- R4: After the on-time ends, a valley can start the next stroke only after demagnetization has been recognised. Valley pulses that arrive before that are ignored. A valley one cycle after the demagnetization pulse turns the gate on one cycle later.
- R5: If `demag_i` stays low, a zero-current event is produced ZCS_TIMEOUT cycles after the gate falls. With no valleys the gate rises again ZCS_TIMEOUT+VALLEY_TIMEOUT cycles after it fell.
- R6: If `valley_i` stays low, a valley event is produced every VALLEY_TIMEOUT cycles after demagnetization. The first one turns the gate on VALLEY_TIMEOUT+1 cycles after the demagnetization pulse.
- R7: Two gate rising edges are never less than MIN_PERIOD cycles apart. A valley that comes too early is skipped and turn-on waits for a later valley.
- R8: `ovp_i` high drives the gate low from the next cycle and holds it low. When the flag clears, the gate rises in the following cycle, provided the minimum period has already elapsed.
- R9: `mains_low_i` halts switching and allows a restart, with the same cycle timing as R8.
- R10: `light_load_i` disables switching and restores it when it clears, with the same cycle timing as R8.
- R11: After arming, with no stop flag set, the first stroke starts without waiting for a valley. The gate rises two cycles after `vout_ok_i` first goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vout_ok_i | input | 1 | Output sense above the open-loop threshold |
| ovp_i | input | 1 | Output overvoltage flag |
| mains_low_i | input | 1 | Mains below the brownout stop level |
| light_load_i | input | 1 | Low-power request from the downstream converter |
| demag_i | input | 1 | Demagnetization (zero current) detected |
| valley_i | input | 1 | Drain-voltage minimum detected |
| ocp_i | input | 1 | Cycle-by-cycle overcurrent flag |
| on_time_i | input | TON_W | On-time in clock cycles, sampled at turn-on |
| gate_o | output | 1 | Power-switch gate command |

## Verification
The stop flags, arming and all timer events pass through exactly one register. Their effect on `gate_o` therefore appears one sample after the input cycle, and `vout_ok_i` takes two samples because it also passes through the arming flop. Overcurrent acts on `gate_o` in the same sample. The bench drives inputs on the falling edge and samples half a nanosecond later. A behavioural model, updated on each rising edge from the same inputs, predicts `gate_o` for every sample. Directed checks then measure pulse widths and the distances between the demagnetization pulse, the falling edge and the rising edge against the cycle counts stated in the requirements.

// File: rtl/pfc_vs_pkg.sv
`timescale 1ns/1ps
package pfc_vs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ON     = 2'd1,
    ST_DEMAG  = 2'd2,
    ST_VALLEY = 2'd3
  } pfc_state_e;

  // Length of a stroke in cycles for a programmed on-time: zero maps to one.
  function automatic logic [31:0] on_len(input logic [31:0] t);
    return (t == 32'd0) ? 32'd1 : t;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pfc_vs_inhibit.sv
`timescale 1ns/1ps
module pfc_vs_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic vout_ok_i,
  input  logic ovp_i,
  input  logic mains_low_i,
  input  logic light_load_i,
  output logic armed_o,
  output logic inhibit_o
);

  logic armed_q;

  // Sticky arming: the loop must have been seen closed once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (vout_ok_i) armed_q <= 1'b1;
  end

  assign armed_o   = armed_q;
  assign inhibit_o = !armed_q || ovp_i || mains_low_i || light_load_i;

  a_r1_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

endmodule

// File: rtl/pfc_vs_period.sv
`timescale 1ns/1ps
module pfc_vs_period #(
  parameter int MIN_PERIOD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic period_ok_o
);

  localparam int PW = pfc_vs_pkg::cnt_width(MIN_PERIOD);

  generate
    if (MIN_PERIOD <= 1) begin : g_nolimit
      logic unused_bits;
      assign unused_bits = start_i ^ clk ^ rst_n;
      assign period_ok_o = 1'b1;
    end else begin : g_limit
      localparam logic [PW-1:0] LIMIT = PW'(MIN_PERIOD);
      logic [PW-1:0] since_q;

      // Cycles since the last turn-on, saturating at the limit.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_q <= LIMIT;
        else if (start_i)        since_q <= PW'(1);
        else if (since_q < LIMIT) since_q <= since_q + 1'b1;
      end

      assign period_ok_o = (since_q >= LIMIT);

      a_r7_since_range: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= LIMIT);
      a_r7_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !period_ok_o);
    end
  endgenerate

endmodule

// File: rtl/pfc_vs_fsm.sv
`timescale 1ns/1ps
module pfc_vs_fsm #(
  parameter int TON_W          = 8,
  parameter int ZCS_TIMEOUT    = 200,
  parameter int VALLEY_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit_i,
  input  logic             period_ok_i,
  input  logic             demag_i,
  input  logic             valley_i,
  input  logic             ocp_i,
  input  logic [TON_W-1:0] on_time_i,
  output logic             on_o,
  output logic             turn_on_o,
  output logic             zcs_evt_o,
  output logic             vly_evt_o
);
  import pfc_vs_pkg::*;

  localparam int WAIT_MAX = (ZCS_TIMEOUT > VALLEY_TIMEOUT) ? ZCS_TIMEOUT : VALLEY_TIMEOUT;
  localparam int WAIT_W   = cnt_width(WAIT_MAX);
  localparam logic [WAIT_W-1:0] ZCS_LAST = WAIT_W'(ZCS_TIMEOUT - 1);
  localparam logic [WAIT_W-1:0] VLY_LAST = WAIT_W'(VALLEY_TIMEOUT - 1);
  localparam logic [TON_W-1:0]  TON_ONE  = TON_W'(1);

  pfc_state_e        st_q;
  logic [TON_W-1:0]  ton_q;
  logic [WAIT_W-1:0] wait_q;
  logic              vly_tick, on_end;

  always_comb begin
    zcs_evt_o = (st_q == ST_DEMAG)  && (demag_i  || (wait_q == ZCS_LAST));
    vly_tick  = (st_q == ST_VALLEY) && (wait_q == VLY_LAST);
    vly_evt_o = (st_q == ST_VALLEY) && (valley_i || vly_tick);
    on_end    = (st_q == ST_ON)     && (ocp_i    || (ton_q <= TON_ONE));
    turn_on_o = !inhibit_i && period_ok_i && ((st_q == ST_IDLE) || vly_evt_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ton_q  <= '0;
      wait_q <= '0;
    end else if (inhibit_i) begin
      st_q <= ST_IDLE;
    end else if (turn_on_o) begin
      st_q  <= ST_ON;
      ton_q <= TON_W'(on_len(32'(on_time_i)));
    end else begin
      unique case (st_q)
        ST_ON: begin
          if (on_end) begin
            st_q   <= ST_DEMAG;
            wait_q <= '0;
          end else begin
            ton_q <= ton_q - 1'b1;
          end
        end
        ST_DEMAG: begin
          if (zcs_evt_o) begin
            st_q   <= ST_VALLEY;
            wait_q <= '0;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_VALLEY: wait_q <= vly_tick ? '0 : wait_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign on_o = (st_q == ST_ON);

  a_r4_no_on_from_demag: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEMAG) |=> (st_q != ST_ON));
  a_r5_zcs_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEMAG) |-> (wait_q <= ZCS_LAST));
  a_r6_valley_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VALLEY) |-> (wait_q <= VLY_LAST));
  a_r3_ocp_ends_stroke: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ON) && ocp_i && !inhibit_i) |=> (st_q == ST_DEMAG));
  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (st_q == ST_IDLE));

endmodule

// File: rtl/pfc_valley_ctrl.sv
`timescale 1ns/1ps
module pfc_valley_ctrl #(
  parameter int TON_W          = 8,
  parameter int ZCS_TIMEOUT    = 200,
  parameter int VALLEY_TIMEOUT = 16,
  parameter int MIN_PERIOD     = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vout_ok_i,
  input  logic             ovp_i,
  input  logic             mains_low_i,
  input  logic             light_load_i,
  input  logic             demag_i,
  input  logic             valley_i,
  input  logic             ocp_i,
  input  logic [TON_W-1:0] on_time_i,
  output logic             gate_o
);

  logic armed, inhibit, period_ok, on, turn_on, zcs_evt, vly_evt;

  pfc_vs_inhibit u_inhibit (
    .clk          (clk),
    .rst_n        (rst_n),
    .vout_ok_i    (vout_ok_i),
    .ovp_i        (ovp_i),
    .mains_low_i  (mains_low_i),
    .light_load_i (light_load_i),
    .armed_o      (armed),
    .inhibit_o    (inhibit)
  );

  pfc_vs_period #(.MIN_PERIOD(MIN_PERIOD)) u_period (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (turn_on),
    .period_ok_o (period_ok)
  );

  pfc_vs_fsm #(
    .TON_W          (TON_W),
    .ZCS_TIMEOUT    (ZCS_TIMEOUT),
    .VALLEY_TIMEOUT (VALLEY_TIMEOUT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .inhibit_i   (inhibit),
    .period_ok_i (period_ok),
    .demag_i     (demag_i),
    .valley_i    (valley_i),
    .ocp_i       (ocp_i),
    .on_time_i   (on_time_i),
    .on_o        (on),
    .turn_on_o   (turn_on),
    .zcs_evt_o   (zcs_evt),
    .vly_evt_o   (vly_evt)
  );

  // Overcurrent cuts the gate without waiting for a clock edge.
  assign gate_o = on && !ocp_i;

  a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !gate_o);
  a_r7_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on) |-> $past(period_ok));
  a_r5_zcs_not_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    (zcs_evt && !inhibit) |=> !on);
  a_r6_valley_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (vly_evt && period_ok && !inhibit) |=> on);

endmodule

// File: tb/pfc_valley_ctrl_tb_top.sv
`timescale 1ns/1ps
module pfc_valley_ctrl_tb_top;
  localparam int TON_W = 8;
  localparam int ZCS   = 200;
  localparam int VT    = 16;
  localparam int MINP  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vout_ok_i = 0, ovp_i = 0, mains_low_i = 0, light_load_i = 0;
  logic demag_i = 0, valley_i = 0, ocp_i = 0;
  logic [TON_W-1:0] on_time_i = 8'd10;
  logic gate_o;

  always #2 clk = ~clk;

  pfc_valley_ctrl #(.TON_W(TON_W), .ZCS_TIMEOUT(ZCS), .VALLEY_TIMEOUT(VT), .MIN_PERIOD(MINP)) dut_i (
    .clk(clk), .rst_n(rst_n), .vout_ok_i(vout_ok_i), .ovp_i(ovp_i), .mains_low_i(mains_low_i),
    .light_load_i(light_load_i), .demag_i(demag_i), .valley_i(valley_i), .ocp_i(ocp_i),
    .on_time_i(on_time_i), .gate_o(gate_o));

  int checks = 0, fails = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 stopped, 1 conducting, 2 awaiting zero current, 3 awaiting valley
  int  m_ph = 0, m_left = 0, m_wait = 0, m_since = MINP;
  bit  m_armed = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_armed = 0; m_since = MINP;
    end else begin
      bit stop, may, go;
      stop = !m_armed || ovp_i || mains_low_i || light_load_i;
      may  = (m_since >= MINP);
      go   = 0;
      if (stop) m_ph = 0;
      else if (m_ph == 0) go = may;
      else if (m_ph == 1) begin
        if (ocp_i || m_left <= 1) begin m_ph = 2; m_wait = 0; end
        else m_left--;
      end else if (m_ph == 2) begin
        if (demag_i || m_wait == ZCS - 1) begin m_ph = 3; m_wait = 0; end
        else m_wait++;
      end else begin
        bit ev;
        ev = valley_i || (m_wait == VT - 1);
        m_wait = (m_wait == VT - 1) ? 0 : m_wait + 1;
        go = ev && may;
      end
      if (go) begin
        m_ph = 1;
        m_left = (on_time_i == 0) ? 1 : int'(on_time_i);
        m_since = 1;
      end else if (m_since < MINP) m_since++;
      if (vout_ok_i) m_armed = 1;
    end
  end

  // Sampler: compare every cycle and record edge times
  int cyc = 0, nrise = 0, nfall = 0, last_rise = 0, last_fall = 0, last_dm = 0;
  int gap = 0, wcur = 0, last_width = 0;
  bit g_prev = 0;
  always @(negedge clk) begin
    #0.5;
    cyc++;
    if (rst_n) begin
      bit mg;
      mg = (m_ph == 1) && !ocp_i;
      check(gate_o == mg, cur_req, int'(gate_o), int'(mg));
    end
    if (gate_o && !g_prev) begin
      nrise++; gap = cyc - last_rise; last_rise = cyc; wcur = 1;
    end else if (gate_o) wcur++;
    if (!gate_o && g_prev) begin nfall++; last_width = wcur; last_fall = cyc; end
    if (demag_i) last_dm = cyc;
    g_prev = gate_o;
  end

  // Power-stage stand-in: demagnetization and valleys relative to the gate falling
  int plant_dm = -1, plant_vp = 0, k = 0;
  always @(negedge clk) begin
    if (g_prev) k = 0; else k++;
    demag_i  = (plant_dm >= 0) && (k == plant_dm);
    valley_i = (plant_vp > 0) && (k > 0) && (k % plant_vp == 0);
  end

  task automatic wait_rise();
    int n0 = nrise;
    while (nrise == n0) begin @(negedge clk); #1; end
  endtask
  task automatic wait_fall();
    int n0 = nfall;
    while (nfall == n0) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic stop_test(input int which, input string req);
    int s, n0;
    cur_req = req;
    wait_rise();
    repeat (3) @(negedge clk);
    case (which)
      0: ovp_i = 1;
      1: mains_low_i = 1;
      default: light_load_i = 1;
    endcase
    n0 = nrise;
    @(negedge clk); #1;
    check(gate_o == 0, req, int'(gate_o), 0);
    repeat (60) @(negedge clk);
    #1;
    check(nrise == n0, req, nrise, n0);
    @(negedge clk);
    ovp_i = 0; mains_low_i = 0; light_load_i = 0;
    s = cyc + 1;
    wait_rise();
    check(last_rise == s + 1, req, last_rise, s + 1);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(gate_o == 0, "R1", int'(gate_o), 0);
    repeat (40) @(negedge clk);
    #1;
    check(nrise == 0, "R1", nrise, 0);

    // R11: arming start, R2 width, R5 fallback zero-current timing
    cur_req = "R11";
    @(negedge clk);
    vout_ok_i = 1;
    s = cyc + 1;
    wait_rise();
    check(last_rise == s + 2, "R11", last_rise, s + 2);
    cur_req = "R2";
    wait_fall();
    check(last_width == 10, "R2", last_width, 10);
    cur_req = "R5";
    wait_rise();
    check(last_rise - last_fall == ZCS + VT, "R5", last_rise - last_fall, ZCS + VT);

    // R6: demagnetization seen, valleys missing
    cur_req = "R6";
    @(negedge clk);
    on_time_i = 8'd40; plant_dm = 5; plant_vp = 0;
    wait_rise(); wait_rise();
    check(last_rise - last_dm == VT + 1, "R6", last_rise - last_dm, VT + 1);

    // R4: valleys also during the demagnetization wait must be ignored
    cur_req = "R4";
    @(negedge clk);
    plant_vp = 3;
    wait_rise(); wait_rise();
    check(last_rise - last_dm == 2, "R4", last_rise - last_dm, 2);

    // R7: short strokes, plentiful valleys
    cur_req = "R7";
    @(negedge clk);
    on_time_i = 8'd4; plant_dm = 2;
    wait_rise(); wait_rise(); wait_rise();
    check(gap >= MINP, "R7", gap, MINP);
    check(gap <= MINP + 2, "R7", gap, MINP + 2);

    // R2: on-time sampled at turn-on, zero gives one cycle
    cur_req = "R2";
    @(negedge clk);
    on_time_i = 8'd12;
    wait_rise(); wait_rise();
    @(negedge clk);
    on_time_i = 8'd30;
    wait_fall();
    check(last_width == 12, "R2", last_width, 12);
    @(negedge clk);
    on_time_i = 8'd0;
    wait_rise(); wait_fall();
    check(last_width == 1, "R2", last_width, 1);

    // R3: overcurrent cuts the stroke in the same cycle
    cur_req = "R3";
    @(negedge clk);
    on_time_i = 8'd40;
    wait_rise(); wait_rise();
    repeat (5) @(negedge clk);
    ocp_i = 1;
    #1;
    check(gate_o == 0, "R3", int'(gate_o), 0);
    @(negedge clk);
    ocp_i = 0;
    #1;
    check(gate_o == 0, "R3", int'(gate_o), 0);
    check(last_width == 5, "R3", last_width, 5);

    stop_test(0, "R8");
    stop_test(1, "R9");
    stop_test(2, "R10");

    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

endmodule